// File: doc/BRIEF.md
# Predicated pairwise signed-minimum vector unit

This block reduces adjacent element pairs to their signed minimum across two vector operands in one pass. Element width is chosen per operation by a two-bit code. Every even result lane takes the smaller of a neighbouring pair from the first operand. Every odd result lane takes the smaller of a neighbouring pair from the second operand. The two sources therefore appear interleaved in the result. A per-byte predicate mask governs the lanes. A disabled lane merges in the first operand's element at that position, so the result can overwrite the first operand in place.

The datapath is combinational: one candidate result is built for each of the four element widths, and the size code selects one of them. A single result register captures the selected vector on a clock edge where `start` is high. The register holds its value at every other edge and is cleared by a synchronous active-high reset. The vector length is a parameter and must be a multiple of 128 bits.

Top module: `pairwise_smin_unit`

## Requirements
- R1: The size code selects the element width: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. The vector holds VLEN divided by that width lanes, and lane e occupies bits [e*w +: w].
- R2: For an active even lane e, the result is the signed minimum of first-operand elements e and e+1.
- R3: For an active odd lane e, the result is the signed minimum of second-operand elements e-1 and e.
- R4: Elements compare as two's-complement values, so the most-negative value is always the smaller of any pair that contains it. Equal elements produce that same value.
- R5: Lane e is active when predicate bit e*w/8, the lowest byte of the lane, is 1. An inactive lane yields the first operand's element e unchanged. The other predicate bits within a lane have no effect.
- R6: On a rising clock edge with `start` high and `rst` low, `result` takes the computed vector. The new value is visible after that edge.
- R7: On a rising clock edge with `start` low and `rst` low, `result` keeps its value whatever the other inputs do.
- R8: On a rising clock edge with `rst` high, `result` becomes zero, even when `start` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture the computed vector at this edge |
| size_sel | input | 2 | Element width code (R1) |
| op_a | input | VLEN | First operand; supplies even lanes and merged lanes |
| op_b | input | VLEN | Second operand; supplies odd lanes |
| pmask | input | VLEN/8 | Predicate, one bit per byte |
| result | output | VLEN | Registered result vector |

## Verification
Two events can meet on the same edge: a capture request and a reset. The bench sets up an operation whose result would be non-zero. It then asserts `rst` and `start` together for one cycle and requires the register to read zero afterwards. After that it runs a normal capture to show that the unit still works. The bench also presents predicate patterns that set only the upper bytes of each lane, which must leave the merged first operand in place. Each result is compared with a model that orders signed values by flipping the sign bit, not by a signed compare.

// File: rtl/pmin_pkg.sv
package pmin_pkg;

  localparam int NUM_SIZES = 4;
  localparam int MAX_EW    = 64;

  // Element width in bits for a size code.
  function automatic int elem_bits(input int code);
    return 8 << code;
  endfunction

  // Sign-extend the low w bits of v to 64 bits.
  function automatic logic signed [63:0] sext(input logic [63:0] v, input int w);
    logic signed [63:0] t;
    t = signed'(v << (64 - w));
    return t >>> (64 - w);
  endfunction

  // Smaller of two signed 64-bit values.
  function automatic logic signed [63:0] smin64(input logic signed [63:0] x,
                                                input logic signed [63:0] y);
    return (x < y) ? x : y;
  endfunction

endpackage

// File: rtl/pmin_slice.sv
module pmin_slice #(
  parameter int VLEN = 256,
  parameter int EW   = 8
) (
  input  logic [VLEN-1:0]    src_a,
  input  logic [VLEN-1:0]    src_b,
  input  logic [VLEN/8-1:0]  pmask,
  output logic [VLEN-1:0]    lanes_out,
  output logic [VLEN/EW-1:0] lane_live
);
  localparam int LANES = VLEN / EW;
  localparam int BPL   = EW / 8;

  // Only the base byte bit of each lane matters; the rest is folded away.
  logic pred_unused;
  assign pred_unused = ^pmask;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    localparam int PB = e * BPL;
    logic [EW-1:0] elem_x;
    logic [EW-1:0] elem_y;
    logic [EW-1:0] pair_min;

    if (e % 2 == 0) begin : g_even
      // R2: even lane pairs come from the first operand
      assign elem_x = src_a[e*EW +: EW];
      assign elem_y = src_a[(e+1)*EW +: EW];
    end else begin : g_odd
      // R3: odd lane pairs come from the second operand
      assign elem_x = src_b[(e-1)*EW +: EW];
      assign elem_y = src_b[e*EW +: EW];
    end

    assign pair_min = EW'(pmin_pkg::smin64(pmin_pkg::sext(64'(elem_x), EW),
                                           pmin_pkg::sext(64'(elem_y), EW)));
    assign lane_live[e] = pmask[PB];
    assign lanes_out[e*EW +: EW] = lane_live[e] ? pair_min : src_a[e*EW +: EW];

    always_comb begin
      if (lane_live[e]) begin
        AST_MIN_BOUND: assert ($signed(lanes_out[e*EW +: EW]) <= $signed(elem_x) &&
                               $signed(lanes_out[e*EW +: EW]) <= $signed(elem_y) &&
                               (lanes_out[e*EW +: EW] == elem_x ||
                                lanes_out[e*EW +: EW] == elem_y)); // R4
      end
    end
  end
endmodule

// File: rtl/pmin_select.sv
module pmin_select #(
  parameter int VLEN = 256,
  parameter int NSZ  = 4
) (
  input  logic [1:0]      size_sel,
  input  logic [VLEN-1:0] cand [NSZ],
  output logic [VLEN-1:0] picked,
  output logic [NSZ-1:0]  size_hot
);
  assign size_hot = NSZ'(1) << size_sel;

  always_comb begin
    picked = '0;
    for (int k = 0; k < NSZ; k++) begin
      if (size_hot[k]) picked = picked | cand[k];
    end
  end

  always_comb begin
    AST_ONE_WIDTH: assert ($countones(size_hot) == 1); // R1
  end
endmodule

// File: rtl/pairwise_smin_unit.sv
module pairwise_smin_unit #(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        size_sel,
  input  logic [VLEN-1:0]   op_a,
  input  logic [VLEN-1:0]   op_b,
  input  logic [VLEN/8-1:0] pmask,
  output logic [VLEN-1:0]   result
);
  localparam int NSZ = pmin_pkg::NUM_SIZES;

  logic [VLEN-1:0] size_vec [NSZ];
  logic [VLEN-1:0] picked;
  logic [NSZ-1:0]  size_hot;
  logic            capture_evt;

  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int EW = pmin_pkg::elem_bits(k);
    logic [VLEN/EW-1:0] live;
    pmin_slice #(.VLEN(VLEN), .EW(EW)) u_slice (
      .src_a     (op_a),
      .src_b     (op_b),
      .pmask     (pmask),
      .lanes_out (size_vec[k]),
      .lane_live (live)
    );
  end

  pmin_select #(.VLEN(VLEN), .NSZ(NSZ)) u_select (
    .size_sel (size_sel),
    .cand     (size_vec),
    .picked   (picked),
    .size_hot (size_hot)
  );

  assign capture_evt = start && !rst;

  always_ff @(posedge clk) begin
    if (rst)              result <= '0;
    else if (capture_evt) result <= picked;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> result == '0); // R8
  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    start |=> result == $past(picked)); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(result)); // R7
endmodule

// File: tb/tb_pairwise_smin_unit.sv
module tb_pairwise_smin_unit;
  localparam int VLEN = 256;
  localparam int PW   = VLEN / 8;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 0;
  logic            rst = 1;
  logic            start = 0;
  logic [1:0]      size_sel = '0;
  logic [VLEN-1:0] op_a = '0;
  logic [VLEN-1:0] op_b = '0;
  logic [PW-1:0]   pmask = '0;
  logic [VLEN-1:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pairwise_smin_unit #(.VLEN(VLEN)) dut (
    .clk(clk), .rst(rst), .start(start), .size_sel(size_sel),
    .op_a(op_a), .op_b(op_b), .pmask(pmask), .result(result)
  );

  function automatic logic [VLEN-1:0] rand_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [63:0] field(input logic [VLEN-1:0] v, input int e, input int w);
    logic [63:0] m;
    m = (w == 64) ? '1 : ((64'd1 << w) - 1);
    return 64'(v >> (e*w)) & m;
  endfunction

  // Independent model: signed order through sign-bit flip and unsigned compare.
  function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                                            input logic [PW-1:0] p, input logic [1:0] sz);
    logic [VLEN-1:0] o;
    int w;
    logic [63:0] flip;
    o = '0;
    w = 8 << sz;
    flip = 64'd1 << (w-1);
    for (int e = 0; e < VLEN/w; e++) begin
      logic [63:0] x, y, r;
      if (e % 2 == 0) begin x = field(a, e, w); y = field(a, e+1, w); end
      else            begin x = field(b, e-1, w); y = field(b, e, w); end
      if (!p[e*w/8]) r = field(a, e, w);
      else           r = ((x ^ flip) < (y ^ flip)) ? x : y;
      o = o | (VLEN'(r) << (e*w));
    end
    return o;
  endfunction

  task automatic chk(input string tag, input logic [VLEN-1:0] got, input logic [VLEN-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, capture on the next rising edge, read at the falling edge after.
  task automatic run_op(input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                        input logic [PW-1:0] p, input logic [1:0] sz);
    @(negedge clk);
    op_a = a; op_b = b; pmask = p; size_sel = sz; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R8 reset value", result, '0);
    rst = 0;
  endtask

  task automatic t_sizes();
    for (int s = 0; s < 4; s++) begin
      logic [VLEN-1:0] a, b;
      a = rand_vec(); b = rand_vec();
      run_op(a, b, '1, 2'(s));
      chk($sformatf("R1 R6 size code %0d", s), result, model(a, b, '1, 2'(s)));
    end
  endtask

  task automatic t_hand_pairs();
    logic [VLEN-1:0] a, b;
    a = '0; b = '0;
    a[31:0] = 32'd5; a[63:32] = -32'sd3;
    b[31:0] = 32'd7; b[63:32] = 32'd2;
    run_op(a, b, '1, 2'b10);
    chk("R2 even lane from first operand", VLEN'(result[31:0]), VLEN'(32'hFFFF_FFFD));
    chk("R3 odd lane from second operand", VLEN'(result[63:32]), VLEN'(32'd2));
  endtask

  task automatic t_equal();
    for (int s = 0; s < 4; s++) begin
      logic [VLEN-1:0] a;
      a = {(VLEN/32){32'h9C9C_9C9C}};
      run_op(a, a, '1, 2'(s));
      chk($sformatf("R4 equal elements size %0d", s), result, a);
    end
  endtask

  task automatic t_mostneg();
    logic [VLEN-1:0] a;
    a = '0; a[7:0] = 8'h80; a[15:8] = 8'h7F;
    run_op(a, a, '1, 2'b00);
    chk("R4 most-negative byte wins", VLEN'(result[7:0]), VLEN'(8'h80));
    for (int s = 0; s < 4; s++) begin
      logic [VLEN-1:0] b;
      int w;
      w = 8 << s;
      a = '0; b = '0;
      for (int e = 0; e < VLEN/w; e++) begin
        a = a | (VLEN'((e % 2 == 0) ? (64'd1 << (w-1)) : ((64'd1 << (w-1)) - 1)) << (e*w));
        b = b | (VLEN'((e % 3 == 0) ? (64'd1 << (w-1)) : 64'd1) << (e*w));
      end
      run_op(a, b, '1, 2'(s));
      chk($sformatf("R4 extremes size %0d", s), result, model(a, b, '1, 2'(s)));
    end
  endtask

  task automatic t_mixed_pred();
    for (int i = 0; i < 12; i++) begin
      logic [VLEN-1:0] a, b;
      logic [PW-1:0] p;
      a = rand_vec(); b = rand_vec(); p = PW'(rand_vec());
      run_op(a, b, p, 2'(i % 4));
      chk($sformatf("R5 random predicate run %0d", i), result, model(a, b, p, 2'(i % 4)));
    end
  endtask

  task automatic t_pred_ignored();
    logic [VLEN-1:0] a, b;
    a = rand_vec(); b = rand_vec();
    run_op(a, b, {(PW/8){8'hFE}}, 2'b11);
    chk("R5 non-base predicate bits ignored", result, a);
  endtask

  task automatic t_hold();
    logic [VLEN-1:0] a, b, keep;
    a = rand_vec(); b = rand_vec();
    run_op(a, b, '1, 2'b01);
    keep = model(a, b, '1, 2'b01);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      op_a = rand_vec(); op_b = rand_vec(); pmask = '1; size_sel = 2'(i);
    end
    @(negedge clk);
    chk("R7 result held without start", result, keep);
  endtask

  task automatic t_reset_start();
    logic [VLEN-1:0] a, b;
    a = rand_vec(); b = rand_vec();
    @(negedge clk);
    op_a = a; op_b = b; pmask = '1; size_sel = 2'b00; start = 1; rst = 1;
    @(negedge clk);
    start = 0; rst = 0;
    chk("R8 reset beats start", result, '0);
    run_op(a, b, '1, 2'b00);
    chk("R6 capture after reset", result, model(a, b, '1, 2'b00));
  endtask

  initial begin
    t_reset();
    t_sizes();
    t_hand_pairs();
    t_equal();
    t_mostneg();
    t_mixed_pred();
    t_pred_ignored();
    t_hold();
    t_reset_start();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule